// File: doc/BRIEF.md
# Flash Status-Read and Write-Enable Command Sequencer

This block is the hardware-driven command engine of a serial NOR flash controller. Software writes a command word into a control register. One bit asks for the flash status register to be read, another asks for the flash write-enable latch to be set. A two-bit field picks one of up to four flash devices. The sequencer builds the opcode itself, selects the chosen device and drives a byte-wide shift engine one byte at a time. It then folds the outcome into the controller status register and can raise an interrupt.

A status read merges the flash status byte into the low byte of the controller status register. A completed write enable sets a per-device write-mode flag at status position 12 plus the device number. Both commands set a transfer-finished flag. A write-complete flag is set by the neighbouring write path. Software clears flags by writing zeros to the status register. While the software-mode bit of the first control register is set, commands are refused. A command that arrives while one is still running is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: A control write with bit 10 set starts a status read. Control bits 13:12 select the device, whose active-low select goes low. The shift port is then offered opcode 0x05, followed by one 0x00 byte whose returned value is captured. The byte returned during the opcode is discarded.
- R2: When a status read ends, status bits 7:0 hold the captured byte. Bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 2 to 4 are block protect and bit 7 is status write protect. Status bit 8 (transfer finished) is also set.
- R3: A control write with bit 11 set offers only opcode 0x06, with no data byte. It then sets status bit 8 and status bit 12 plus the device number, and leaves status bits 7:0 unchanged.
- R4: Command bits written while the software-mode input is high start nothing: no byte is offered and the status is unchanged.
- R5: Command bits written while a command is in progress (busy high) are ignored. Busy stays high from the edge that accepts a command until the edge that updates the status.
- R6: If bits 10 and 11 are both set, the status read is performed and no write-mode flag changes.
- R7: The interrupt output is high exactly when status bit 8 and control bit 8 are both set, or when status bit 9 and control bit 9 are both set. Every control write updates both enables.
- R8: A pulse on the write-complete input sets status bit 9.
- R9: A status-register write clears each status bit whose written bit is 0 and keeps the others, so writing zero clears every flag including the write-mode flags. A flag set by hardware in the same cycle survives the clear.
- R10: At most one device select is low. All selects are high when idle and during the cycle before the status update.
- R11: After reset the status is zero, the interrupt is low, busy is low and all selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode_i | input | 1 | Software-mode bit of control register 1; high blocks commands |
| ctl_wr_i | input | 1 | Write strobe for control register 2 |
| ctl_wdata_i | input | 16 | Control register 2 write data |
| stat_wr_i | input | 1 | Write strobe for the status register |
| stat_wdata_i | input | 16 | Status write data; zero bits clear flags |
| wcomp_i | input | 1 | Write-complete event from the memory write path |
| stat_o | output | 16 | Controller status register |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | A command is in progress |
| cs_n_o | output | 4 | Active-low device selects |
| sh_go_o | output | 1 | One-cycle request to shift out one byte |
| sh_tx_o | output | 8 | Byte to shift out, valid with sh_go_o |
| sh_done_i | input | 1 | Shift engine finished the current byte |
| sh_rx_i | input | 8 | Byte shifted in, valid with sh_done_i |

## Verification
A wrong sequencer state shows on the device selects and the shift request within one cycle. A lost command leaves busy low the cycle after the control write. A command stuck in flight keeps a select low after the last byte acknowledgement. A wrong status merge, such as a stale data byte, a write-mode flag on the wrong device or a clear that loses a same-cycle hardware set, shows on the status output on the edge after the final acknowledgement or after the status write. A wrong interrupt enable shows on the interrupt pin in the same cycle. The reference model is compared against the status, interrupt, busy and select outputs on every cycle, so each of these faults is reported at the first cycle where it differs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int STAT_W    = 16;
  localparam int CTL_W     = 16;
  localparam int BYTE_W    = 8;

  // status register flag positions
  localparam int TFF_BIT   = 8;
  localparam int WCF_BIT   = 9;
  localparam int WM_BASE   = 12;

  // control register 2 field positions
  localparam int CTL_TFIE  = 8;
  localparam int CTL_WCIE  = 9;
  localparam int CTL_RDSR  = 10;
  localparam int CTL_WREN  = 11;
  localparam int CTL_BANK  = 12;

  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_PAD  = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_OP_GO, S_OP_WAIT, S_DAT_GO, S_DAT_WAIT, S_FIN
  } seq_state_e;

  typedef enum logic { CMD_RDSR, CMD_WREN } cmd_e;

  function automatic logic [BYTE_W-1:0] opcode_of(cmd_e c);
    return (c == CMD_RDSR) ? OP_RDSR : OP_WREN;
  endfunction

  // bytes exchanged for a command: opcode plus optional data byte
  function automatic int unsigned bytes_of(cmd_e c);
    return (c == CMD_RDSR) ? 2 : 1;
  endfunction

  function automatic int unsigned wm_pos(int unsigned bank);
    return WM_BASE + bank;
  endfunction

endpackage

// File: rtl/seq_ctl_decode.sv
module seq_ctl_decode
  import flash_seq_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_mode_i,
  input  logic                 ctl_wr_i,
  input  logic [CTL_W-1:0]     ctl_wdata_i,
  input  logic                 busy_i,
  output logic                 trig_o,
  output cmd_e                 trig_cmd_o,
  output logic [BANK_W-1:0]    trig_bank_o,
  output logic                 ie_tff_o,
  output logic                 ie_wc_o
);

  localparam logic [CTL_W-1:0] USED_MASK =
    (CTL_W'(1) << CTL_TFIE) | (CTL_W'(1) << CTL_WCIE) |
    (CTL_W'(1) << CTL_RDSR) | (CTL_W'(1) << CTL_WREN) |
    (((CTL_W'(1) << BANK_W) - CTL_W'(1)) << CTL_BANK);

  logic req_any;
  logic req_blocked_sw;
  logic req_blocked_busy;
  logic unused_ctl_bits;

  assign unused_ctl_bits  = ^(ctl_wdata_i & ~USED_MASK);
  assign req_any          = ctl_wdata_i[CTL_RDSR] | ctl_wdata_i[CTL_WREN];
  assign req_blocked_sw   = ctl_wr_i & req_any & sw_mode_i;
  assign req_blocked_busy = ctl_wr_i & req_any & busy_i;

  assign trig_o      = ctl_wr_i & req_any & ~req_blocked_sw & ~req_blocked_busy;
  // status read wins when both request bits are written together (R6)
  assign trig_cmd_o  = ctl_wdata_i[CTL_RDSR] ? CMD_RDSR : CMD_WREN;
  assign trig_bank_o = ctl_wdata_i[CTL_BANK +: BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_tff_o <= 1'b0;
      ie_wc_o  <= 1'b0;
    end else if (ctl_wr_i) begin
      ie_tff_o <= ctl_wdata_i[CTL_TFIE];
      ie_wc_o  <= ctl_wdata_i[CTL_WCIE];
    end
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  cmd_e               trig_cmd_i,
  input  logic [BANK_W-1:0]  trig_bank_i,
  input  logic               sh_done_i,
  input  logic [BYTE_W-1:0]  sh_rx_i,
  output logic               sh_go_o,
  output logic [BYTE_W-1:0]  sh_tx_o,
  output logic [NBANK-1:0]   cs_n_o,
  output logic               busy_o,
  output logic               fin_rd_o,
  output logic               fin_we_o,
  output logic [BANK_W-1:0]  fin_bank_o,
  output logic [BYTE_W-1:0]  rx_byte_o
);

  seq_state_e         state_q;
  cmd_e               cmd_q;
  logic [BANK_W-1:0]  bank_q;
  logic [BYTE_W-1:0]  rx_q;
  logic               selecting;
  logic               last_byte_done;

  assign last_byte_done = sh_done_i &&
    (((state_q == S_OP_WAIT) && (bytes_of(cmd_q) == 1)) || (state_q == S_DAT_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_RDSR;
      bank_q  <= '0;
      rx_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (trig_i) begin
          state_q <= S_OP_GO;
          cmd_q   <= trig_cmd_i;
          bank_q  <= trig_bank_i;
        end
        S_OP_GO:    state_q <= S_OP_WAIT;
        S_OP_WAIT:  if (sh_done_i) state_q <= last_byte_done ? S_FIN : S_DAT_GO;
        S_DAT_GO:   state_q <= S_DAT_WAIT;
        S_DAT_WAIT: if (sh_done_i) begin
          rx_q    <= sh_rx_i;
          state_q <= S_FIN;
        end
        S_FIN:      state_q <= S_IDLE;
        default:    state_q <= S_IDLE;
      endcase
    end
  end

  assign selecting  = state_q inside {S_OP_GO, S_OP_WAIT, S_DAT_GO, S_DAT_WAIT};
  assign busy_o     = (state_q != S_IDLE);
  assign sh_go_o    = (state_q == S_OP_GO) || (state_q == S_DAT_GO);
  assign sh_tx_o    = (state_q == S_OP_GO)  ? opcode_of(cmd_q) :
                      (state_q == S_DAT_GO) ? OP_PAD : '0;
  assign fin_rd_o   = (state_q == S_FIN) && (cmd_q == CMD_RDSR);
  assign fin_we_o   = (state_q == S_FIN) && (cmd_q == CMD_WREN);
  assign fin_bank_o = bank_q;
  assign rx_byte_o  = rx_q;

  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    assign cs_n_o[g] = !(selecting && (bank_q == BANK_W'(g)));
  end

  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o || fin_rd_o || fin_we_o) |-> (&cs_n_o));

  assert_ack_ends_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done_i && !sh_go_o && busy_o && (sh_tx_o == '0) && last_byte_done) |=> !sh_go_o);

endmodule

// File: rtl/seq_status.sv
module seq_status
  import flash_seq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_wr_i,
  input  logic [STAT_W-1:0]  stat_wdata_i,
  input  logic               wcomp_i,
  input  logic               fin_rd_i,
  input  logic               fin_we_i,
  input  logic [BANK_W-1:0]  fin_bank_i,
  input  logic [BYTE_W-1:0]  rx_byte_i,
  input  logic               ie_tff_i,
  input  logic               ie_wc_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               irq_o
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_d;
  logic              hw_set;

  assign hw_set = fin_rd_i | fin_we_i | wcomp_i;

  always_comb begin
    stat_d = stat_q;
    if (stat_wr_i) stat_d = stat_d & stat_wdata_i;   // zeros clear
    if (fin_rd_i) begin
      stat_d[BYTE_W-1:0] = rx_byte_i;
      stat_d[TFF_BIT]    = 1'b1;
    end
    if (fin_we_i) begin
      stat_d[TFF_BIT] = 1'b1;
      for (int b = 0; b < NBANK; b++)
        if (fin_bank_i == BANK_W'(b)) stat_d[wm_pos(b)] = 1'b1;
    end
    if (wcomp_i) stat_d[WCF_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = (stat_q[TFF_BIT] & ie_tff_i) | (stat_q[WCF_BIT] & ie_wc_i);

  assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_rd_i || fin_we_i) |=> stat_q[TFF_BIT]);

  assert_wm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_we_i |=> (|stat_q[WM_BASE +: NBANK]));

  assert_zero_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && (stat_wdata_i == '0) && !hw_set) |=> (stat_q == '0));

  assert_wc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wcomp_i |=> stat_q[WCF_BIT]);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_q[TFF_BIT] || stat_q[WCF_BIT]));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_mode_i,
  input  logic               ctl_wr_i,
  input  logic [15:0]        ctl_wdata_i,
  input  logic               stat_wr_i,
  input  logic [15:0]        stat_wdata_i,
  input  logic               wcomp_i,
  output logic [15:0]        stat_o,
  output logic               irq_o,
  output logic               busy_o,
  output logic [NBANK-1:0]   cs_n_o,
  output logic               sh_go_o,
  output logic [7:0]         sh_tx_o,
  input  logic               sh_done_i,
  input  logic [7:0]         sh_rx_i
);

  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              trig;
  cmd_e              trig_cmd;
  logic [BANK_W-1:0] trig_bank;
  logic              ie_tff, ie_wc;
  logic              fin_rd, fin_we;
  logic [BANK_W-1:0] fin_bank;
  logic [7:0]        rx_byte;

  seq_ctl_decode #(.BANK_W(BANK_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sw_mode_i(sw_mode_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .busy_i(busy_o),
    .trig_o(trig), .trig_cmd_o(trig_cmd), .trig_bank_o(trig_bank),
    .ie_tff_o(ie_tff), .ie_wc_o(ie_wc)
  );

  seq_fsm #(.NBANK(NBANK), .BANK_W(BANK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_cmd_i(trig_cmd),
    .trig_bank_i(trig_bank), .sh_done_i(sh_done_i), .sh_rx_i(sh_rx_i),
    .sh_go_o(sh_go_o), .sh_tx_o(sh_tx_o), .cs_n_o(cs_n_o), .busy_o(busy_o),
    .fin_rd_o(fin_rd), .fin_we_o(fin_we), .fin_bank_o(fin_bank),
    .rx_byte_o(rx_byte)
  );

  seq_status #(.NBANK(NBANK), .BANK_W(BANK_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
    .wcomp_i(wcomp_i), .fin_rd_i(fin_rd), .fin_we_i(fin_we),
    .fin_bank_i(fin_bank), .rx_byte_i(rx_byte), .ie_tff_i(ie_tff),
    .ie_wc_i(ie_wc), .stat_o(stat_o), .irq_o(irq_o)
  );

  assert_sw_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && sw_mode_i && !busy_o) |=> !busy_o);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !sw_mode_i && !busy_o && (ctl_wdata_i[CTL_RDSR] || ctl_wdata_i[CTL_WREN]))
      |=> (busy_o && sh_go_o));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int NB = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n = 1'b0;
  logic        sw_mode = 1'b0, ctl_wr = 1'b0, stat_wr = 1'b0, wcomp = 1'b0;
  logic [15:0] ctl_wdata = '0, stat_wdata = '0;
  logic        sh_done = 1'b0;
  logic [7:0]  sh_rx = '0;
  logic [15:0] stat_o;
  logic        irq_o, busy_o, sh_go_o;
  logic [NB-1:0] cs_n_o;
  logic [7:0]  sh_tx_o;

  flash_cmd_seq #(.NBANK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .sw_mode_i(sw_mode), .ctl_wr_i(ctl_wr),
    .ctl_wdata_i(ctl_wdata), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .wcomp_i(wcomp), .stat_o(stat_o), .irq_o(irq_o), .busy_o(busy_o),
    .cs_n_o(cs_n_o), .sh_go_o(sh_go_o), .sh_tx_o(sh_tx_o),
    .sh_done_i(sh_done), .sh_rx_i(sh_rx)
  );

  int n_chk = 0, n_fail = 0, n_go = 0;
  bit live = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_stat;
  bit m_tfie, m_wcie, m_busy, m_fin, m_rd, fin_now, trig_now;
  int m_rem, m_bank;
  logic [7:0] m_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_tfie = 0; m_wcie = 0; m_busy = 0; m_fin = 0;
      m_rd = 0; m_rem = 0; m_bank = 0; m_rx = '0;
    end else begin
      fin_now  = m_fin;
      trig_now = ctl_wr && !m_busy && !sw_mode && (ctl_wdata[10] || ctl_wdata[11]);
      if (m_busy && !m_fin && sh_done) begin
        m_rem--;
        if (m_rem == 0) begin
          if (m_rd) m_rx = sh_rx;
          m_fin = 1;
        end
      end
      if (stat_wr) m_stat = m_stat & stat_wdata;
      if (fin_now) begin
        m_stat[8] = 1'b1;
        if (m_rd) m_stat[7:0] = m_rx;
        else      m_stat[12 + m_bank] = 1'b1;
        m_busy = 0; m_fin = 0;
      end
      if (wcomp) m_stat[9] = 1'b1;
      if (ctl_wr) begin m_tfie = ctl_wdata[8]; m_wcie = ctl_wdata[9]; end
      if (trig_now) begin
        m_busy = 1; m_rd = ctl_wdata[10]; m_bank = int'(ctl_wdata[13:12]);
        m_rem = m_rd ? 2 : 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      logic [NB-1:0] exp_cs;
      exp_cs = (m_busy && !m_fin) ? ~(NB'(1) << m_bank) : '1;
      chk(stat_o === m_stat, "R2 R3 R8 R9 status per cycle", 32'(stat_o), 32'(m_stat));
      chk(irq_o === ((m_stat[8] & m_tfie) | (m_stat[9] & m_wcie)), "R7 irq per cycle",
          32'(irq_o), 32'((m_stat[8] & m_tfie) | (m_stat[9] & m_wcie)));
      chk(busy_o === m_busy, "R5 busy per cycle", 32'(busy_o), 32'(m_busy));
      chk(cs_n_o === exp_cs, "R10 select per cycle", 32'(cs_n_o), 32'(exp_cs));
      if (sh_go_o) n_go++;
    end
  end

  function automatic logic [15:0] mk(bit rd, bit we, int bank, bit tf, bit wc);
    logic [15:0] v = '0;
    v[10] = rd; v[11] = we; v[13:12] = bank[1:0]; v[8] = tf; v[9] = wc;
    return v;
  endfunction

  task automatic xfer(input logic [15:0] cw, input bit is_rd, input logic [7:0] rx,
                      input int bank, input int lat, input logic [15:0] inject, input string tag);
    logic [7:0] op;
    op = is_rd ? 8'h05 : 8'h06;
    @(negedge clk); ctl_wr = 1; ctl_wdata = cw;
    @(negedge clk); ctl_wr = 0;
    chk(sh_go_o === 1'b1 && sh_tx_o === op, tag, {23'b0, sh_go_o, sh_tx_o}, {23'b0, 1'b1, op});
    chk(cs_n_o === ~(NB'(1) << bank), "R1 device select", 32'(cs_n_o), 32'(~(NB'(1) << bank)));
    for (int i = 0; i < lat; i++) begin
      if (i == 1 && inject != '0) begin ctl_wr = 1; ctl_wdata = inject; end
      @(negedge clk); ctl_wr = 0;
    end
    sh_done = 1; sh_rx = 8'hA5;
    @(negedge clk); sh_done = 0;
    if (is_rd) begin
      chk(sh_go_o === 1'b1 && sh_tx_o === 8'h00, "R1 pad byte", {23'b0, sh_go_o, sh_tx_o}, 32'h100);
      for (int i = 0; i < lat; i++) @(negedge clk);
      sh_done = 1; sh_rx = rx;
      @(negedge clk); sh_done = 0;
    end else begin
      chk(sh_go_o === 1'b0, "R3 no data byte", 32'(sh_go_o), 32'h0);
    end
    chk(&cs_n_o, "R10 released before result", 32'(cs_n_o), 32'hF);
    @(negedge clk);
    chk(busy_o === 1'b0, "R5 idle after result", 32'(busy_o), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int go0;
    repeat (3) @(negedge clk);
    chk(stat_o === 16'h0, "R11 reset status", 32'(stat_o), 32'h0);
    chk(irq_o === 1'b0 && busy_o === 1'b0, "R11 reset irq busy", {30'b0, irq_o, busy_o}, 32'h0);
    chk(cs_n_o === 4'hF, "R11 reset selects", 32'(cs_n_o), 32'hF);
    rst_n = 1; live = 1;

    // enable transfer-finished interrupt only
    @(negedge clk); ctl_wr = 1; ctl_wdata = mk(0, 0, 0, 1, 0);
    @(negedge clk); ctl_wr = 0;

    xfer(mk(1, 0, 0, 1, 0), 1, 8'h83, 0, 2, '0, "R1 status read opcode");
    chk(stat_o === 16'h0183, "R2 status byte merged", 32'(stat_o), 32'h0183);
    chk(irq_o === 1'b1, "R7 irq on finished flag", 32'(irq_o), 32'h1);

    xfer(mk(0, 1, 2, 1, 0), 0, 8'h00, 2, 3, '0, "R3 write enable opcode");
    chk(stat_o === 16'h4183, "R3 write-mode flag bank 2", 32'(stat_o), 32'h4183);

    @(negedge clk); stat_wr = 1; stat_wdata = 16'hFEFF;
    @(negedge clk); stat_wr = 0;
    chk(stat_o === 16'h4083, "R9 partial clear", 32'(stat_o), 32'h4083);
    chk(irq_o === 1'b0, "R7 irq drops with flag", 32'(irq_o), 32'h0);

    go0 = n_go; sw_mode = 1;
    @(negedge clk); ctl_wr = 1; ctl_wdata = mk(1, 0, 1, 1, 0);
    @(negedge clk); ctl_wr = 0;
    repeat (8) @(negedge clk);
    chk(n_go == go0 && busy_o === 1'b0, "R4 blocked in software mode", 32'(n_go - go0), 32'h0);
    chk(stat_o === 16'h4083, "R4 status unchanged", 32'(stat_o), 32'h4083);
    sw_mode = 0;

    xfer(mk(1, 1, 3, 1, 0), 1, 8'h1C, 3, 2, '0, "R6 read wins opcode");
    chk(stat_o === 16'h411C, "R6 no write-mode change", 32'(stat_o), 32'h411C);

    go0 = n_go;
    xfer(mk(0, 1, 1, 1, 0), 0, 8'h00, 1, 3, mk(1, 0, 3, 1, 1), "R5 write enable opcode");
    chk(n_go == go0 + 1, "R5 busy request dropped", 32'(n_go - go0), 32'h1);
    chk(stat_o === 16'h611C, "R5 only first command applied", 32'(stat_o), 32'h611C);

    @(negedge clk); wcomp = 1;
    @(negedge clk); wcomp = 0;
    chk(stat_o === 16'h631C, "R8 write-complete flag", 32'(stat_o), 32'h631C);
    chk(irq_o === 1'b1, "R7 irq enables", 32'(irq_o), 32'h1);

    @(negedge clk); stat_wr = 1; stat_wdata = 16'h0; wcomp = 1;
    @(negedge clk); stat_wr = 0; wcomp = 0;
    chk(stat_o === 16'h0200, "R9 hardware set survives clear", 32'(stat_o), 32'h0200);
    @(negedge clk); stat_wr = 1; stat_wdata = 16'h0;
    @(negedge clk); stat_wr = 0;
    chk(stat_o === 16'h0000, "R9 zero write clears all", 32'(stat_o), 32'h0);

    xfer(mk(1, 0, 1, 0, 0), 1, 8'hFF, 1, 1, '0, "R1 status read short latency");
    chk(stat_o === 16'h01FF && irq_o === 1'b0, "R7 irq masked", {15'b0, irq_o, stat_o}, 32'h01FF);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule